// File: doc/BRIEF.md
# Flyback Charger Switching Sequencer

This block is the digital controller of a flyback capacitor charger. It drives the gate of a single primary-side power switch. It decides each on-time and off-time from digital flags that external comparators produce: peak-current trip, secondary-discharge (valley) detect, output-target trip, regulation-low and undervoltage. A charge-enable input starts and stops the whole process. A trigger-halt request pauses switching while the output is being topped up. An active-low done output reports that the target voltage has been reached.

A charge begins in a soft-start mode with a fixed off-time. Once the valley detector keeps firing inside that fixed window for several cycles in a row, the block moves to a fast mode. In fast mode a new on-time starts as soon as the valley is seen, and a timeout still restarts the switch if no valley arrives. After completion the block either waits for the regulation-low flag and then recharges, or, when regulation is strapped off, stays idle until charge enable is cycled. All asynchronous flags pass through two-flop synchronisers. Every timer length is a parameter counted in clock cycles.

Top module: `fbk_charge_seq`

## Requirements
- R1: During and straight after reset, gate_o is low and done_n_o is high.
- R2: A change on chg_en_i takes effect only after the synchronised level has differed from the accepted level for FILT_CYC consecutive cycles. After a falling edge, done_n_o rises on the (FILT_CYC+3)-th clock edge. A pulse shorter than FILT_CYC cycles is ignored.
- R3: Each on-time ends three clock edges after ilim_i rises, or after TON_MAX cycles of gate high, whichever comes first.
- R4: In soft-start mode every off-time lasts exactly TOFF_FIX cycles, whether or not valley_i asserts.
- R5: After FAST_CNT consecutive soft off-times in each of which valley_i was seen, the block enters fast mode. There an off-time ends three edges after valley_i rises. Fast mode persists through completion and recharge.
- R6: In fast mode, if no valley arrives, the off-time ends after TOFF_MAX cycles.
- R7: A target_i trip during charging stops switching and pulls done_n_o low on the third edge. done_n_o stays low, even after target_i falls, until charging restarts or charge enable is removed.
- R8: With regulation enabled (reg_off_i low), reg_low_i after completion restarts switching and releases done_n_o on the third edge. Charging then runs until target_i trips again.
- R9: With reg_off_i high, reg_low_i has no effect after completion: the gate stays low and done_n_o stays low until charge enable falls and rises again.
- R10: A filtered low on charge enable forces gate_o low and done_n_o high, and returns the block to soft-start mode for the next charge.
- R11: halt_i during a recharge holds gate_o low from the third edge until halt_i is removed, after which switching resumes. halt_i during the first charge after enable is ignored.
- R12: uvlo_i forces gate_o low and done_n_o high from the third edge. Switching restarts once uvlo_i clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chg_en_i | input | 1 | Charge enable, asynchronous, filtered |
| ilim_i | input | 1 | Peak current limit reached |
| valley_i | input | 1 | Secondary discharged / switch valley detected |
| target_i | input | 1 | Output target voltage reached |
| reg_low_i | input | 1 | Regulation level has drooped below threshold |
| reg_off_i | input | 1 | Strap: 1 disables automatic recharge |
| uvlo_i | input | 1 | Supply undervoltage lockout |
| halt_i | input | 1 | Trigger-halt request |
| gate_o | output | 1 | Power switch gate drive, 1 = on |
| done_n_o | output | 1 | Active-low charge complete |

## Verification
Several pairs of events can land in the same cycle. The most delicate pair is a trigger-halt request that arrives while a recharge pulse is in progress, and in the same stretch the valley and current-limit plant model keeps toggling its flags. The bench raises halt_i at a negedge in the middle of a recharge. It requires gate_o to be low three edges later and to stay low over a long window. It then requires pulses to resume once halt_i drops. The same halt held high through a fresh first charge must leave switching untouched. Off-time and on-time widths are measured by a plant model that reacts to gate_o and are compared with widths computed from the requirements.

// File: rtl/fbk_pkg.sv
// Package: shared state encoding for the flyback charge sequencer.
package fbk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // standby, switch off
        ST_ON   = 3'd1,   // switch conducting
        ST_OFF  = 3'd2,   // switch off, waiting for next cycle
        ST_DONE = 3'd3,   // target reached
        ST_HALT = 3'd4    // recharge paused by halt request
    } fbk_state_e;
endpackage

// File: rtl/fbk_sync.sv
// Module: fbk_sync
// Two-flop synchroniser for a bus of independent asynchronous flags.
// Assumes each bit is a slow level; no bus coherence is implied.
module fbk_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // Two register stages, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/fbk_en_filter.sv
// Module: fbk_en_filter
// Accepts a new level of the enable only after it has differed from the
// accepted level for FILT_CYC consecutive cycles. Input must be synchronous.
module fbk_en_filter #(
    parameter int FILT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles of disagreement; commit the new level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_o <= 1'b0;
        end else if (raw_i == filt_o) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            filt_o <= raw_i;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the accepted level moves only once the count has run out
    assert_filter_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_o != $past(filt_o)) |-> ($past(cnt_q) == CNT_LAST));
endmodule

// File: rtl/fbk_mode_track.sv
// Module: fbk_mode_track
// Tracks consecutive soft-start off-times that saw a valley; after FAST_CNT
// in a row it sets a sticky fast-mode flag, cleared only by clr_i.
module fbk_mode_track #(
    parameter int FAST_CNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic off_end_i,
    input  logic valley_hit_i,
    output logic fast_o
);
    localparam int SW = $clog2(FAST_CNT + 1);
    localparam logic [SW-1:0] STREAK_LAST = SW'(FAST_CNT - 1);

    logic [SW-1:0] streak_q;

    // Streak counter and sticky mode flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            streak_q <= '0;
            fast_o   <= 1'b0;
        end else if (off_end_i && !fast_o) begin
            if (!valley_hit_i) begin
                streak_q <= '0;
            end else if (streak_q == STREAK_LAST) begin
                streak_q <= '0;
                fast_o   <= 1'b1;
            end else begin
                streak_q <= streak_q + 1'b1;
            end
        end
    end

    // R5: fast mode is entered only at the end of a valley-qualified off-time
    assert_fast_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fast_o) |-> $past(off_end_i && valley_hit_i));
endmodule

// File: rtl/fbk_charge_seq.sv
// Module: fbk_charge_seq
// Switching sequencer of a flyback capacitor charger. Drives one gate from
// synchronised comparator flags: soft-start fixed off-time, valley-triggered
// fast mode, current-limit / max on-time, completion, regulated recharge,
// halt and undervoltage lockout. All timers are in clock cycles.
module fbk_charge_seq
    import fbk_pkg::*;
#(
    parameter int FILT_CYC = 1000,
    parameter int TON_MAX  = 900,
    parameter int TOFF_FIX = 900,
    parameter int TOFF_MAX = 900,
    parameter int FAST_CNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_en_i,
    input  logic ilim_i,
    input  logic valley_i,
    input  logic target_i,
    input  logic reg_low_i,
    input  logic reg_off_i,
    input  logic uvlo_i,
    input  logic halt_i,
    output logic gate_o,
    output logic done_n_o
);
    localparam int TMAX_A = (TON_MAX > TOFF_FIX) ? TON_MAX : TOFF_FIX;
    localparam int TMAX   = (TMAX_A > TOFF_MAX) ? TMAX_A : TOFF_MAX;
    localparam int TW     = $clog2(TMAX + 1);
    localparam logic [TW-1:0] T_ON_LAST   = TW'(TON_MAX - 1);
    localparam logic [TW-1:0] T_FIX_LAST  = TW'(TOFF_FIX - 1);
    localparam logic [TW-1:0] T_OMAX_LAST = TW'(TOFF_MAX - 1);
    localparam int NFLAG = 8;

    logic [NFLAG-1:0] flag_raw, flag_s;
    logic chg_s, ilim_s, valley_s, target_s, reg_low_s, reg_off_s, uvlo_s, halt_s;
    logic en_f;
    logic fast;
    fbk_state_e state_q, state_d;
    logic [TW-1:0] tmr_q;
    logic recharge_q;
    logic valley_seen_q;
    logic off_end;
    logic idle_clr;

    assign flag_raw = {chg_en_i, ilim_i, valley_i, target_i,
                       reg_low_i, reg_off_i, uvlo_i, halt_i};
    assign {chg_s, ilim_s, valley_s, target_s,
            reg_low_s, reg_off_s, uvlo_s, halt_s} = flag_s;

    fbk_sync #(.W(NFLAG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (flag_raw),
        .q_o   (flag_s)
    );

    fbk_en_filter #(.FILT_CYC(FILT_CYC)) u_en_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (chg_s),
        .filt_o (en_f)
    );

    assign off_end  = (state_q == ST_OFF) && (state_d == ST_ON) && !fast;
    assign idle_clr = (state_q == ST_IDLE);

    fbk_mode_track #(.FAST_CNT(FAST_CNT)) u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (idle_clr),
        .off_end_i    (off_end),
        .valley_hit_i (valley_seen_q | valley_s),
        .fast_o       (fast)
    );

    // Next-state decision; enable loss and UVLO take priority over all else.
    always_comb begin
        state_d = state_q;
        if (!en_f || uvlo_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_ON;
                ST_ON: begin
                    if (target_s)                    state_d = ST_DONE;
                    else if (halt_s && recharge_q)   state_d = ST_HALT;
                    else if (ilim_s || tmr_q == T_ON_LAST) state_d = ST_OFF;
                end
                ST_OFF: begin
                    if (target_s)                    state_d = ST_DONE;
                    else if (halt_s && recharge_q)   state_d = ST_HALT;
                    else if (fast) begin
                        if (valley_s || tmr_q == T_OMAX_LAST) state_d = ST_ON;
                    end else if (tmr_q == T_FIX_LAST) begin
                        state_d = ST_ON;
                    end
                end
                ST_DONE: begin
                    if (!reg_off_s && reg_low_s)
                        state_d = halt_s ? ST_HALT : ST_ON;
                end
                ST_HALT: begin
                    if (target_s)     state_d = ST_DONE;
                    else if (!halt_s) state_d = ST_ON;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register and per-phase cycle timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                tmr_q <= '0;
            else if (state_q == ST_ON || state_q == ST_OFF)
                tmr_q <= tmr_q + 1'b1;
        end
    end

    // Recharge flag: set when leaving completion, cleared in standby.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE)
            recharge_q <= 1'b0;
        else if (state_q == ST_DONE && state_d != ST_DONE)
            recharge_q <= 1'b1;
    end

    // Valley memory over the current off-time.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_OFF)
            valley_seen_q <= 1'b0;
        else if (valley_s)
            valley_seen_q <= 1'b1;
    end

    assign gate_o   = (state_q == ST_ON);
    assign done_n_o = (state_q != ST_DONE);

    // Run-length of the gate-high phase, used only by the checks below.
    logic [TW-1:0] on_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !gate_o) on_run_q <= '0;
        else                   on_run_q <= on_run_q + 1'b1;
    end

    // R3: no on-time lasts longer than TON_MAX cycles
    assert_ton_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> (on_run_q < TW'(TON_MAX)));

    // R12: undervoltage switches the gate off on the next edge
    assert_uvlo_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_s |=> !gate_o);

    // R11: halt during a recharge keeps the gate off
    assert_halt_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_s && recharge_q) |=> !gate_o);

    // R7: done is asserted only after a target trip was seen
    assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_n_o) |-> $past(target_s));

    // R10: filtered enable low turns the gate off and releases done
    assert_enable_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_f |=> (!gate_o && done_n_o));
endmodule

// File: tb/fbk_charge_seq_bench.sv
module fbk_charge_seq_bench;
    localparam int FILT = 16;
    localparam int TON  = 40;
    localparam int TOFF_F = 40;
    localparam int TOFF_M = 30;
    localparam int FAST = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chg_en = 1'b0, ilim = 1'b0, valley = 1'b0, target = 1'b0;
    logic reg_low = 1'b0, reg_off = 1'b0, uvlo = 1'b0, halt = 1'b0;
    logic gate, done_n;

    int vectors = 0;
    int miscompares = 0;

    // plant model state
    int hi = 0, lo = 0, last_hi = 0, last_lo = 0, n_hi = 0, n_lo = 0;
    bit seen_hi = 0;
    bit plant_ilim = 0, plant_val = 0;
    int ilim_at = 10, val_at = 5;
    int clr_tok = 0, clr_seen = 0;

    always #10 clk = ~clk;

    fbk_charge_seq #(.FILT_CYC(FILT), .TON_MAX(TON), .TOFF_FIX(TOFF_F),
                     .TOFF_MAX(TOFF_M), .FAST_CNT(FAST)) u_fbk_charge_seq (
        .clk(clk), .rst_n(rst_n), .chg_en_i(chg_en), .ilim_i(ilim),
        .valley_i(valley), .target_i(target), .reg_low_i(reg_low),
        .reg_off_i(reg_off), .uvlo_i(uvlo), .halt_i(halt),
        .gate_o(gate), .done_n_o(done_n));

    // Plant: measures pulse widths and answers with ilim / valley flags.
    always @(negedge clk) begin
        if (clr_tok != clr_seen) begin
            clr_seen = clr_tok;
            seen_hi = 0;
        end
        if (gate) begin
            if (lo > 0 && seen_hi) begin last_lo = lo; n_lo = n_lo + 1; end
            lo = 0; hi = hi + 1; seen_hi = 1;
            valley = 1'b0;
            if (plant_ilim && hi >= ilim_at) ilim = 1'b1;
        end else begin
            if (hi > 0) begin last_hi = hi; n_hi = n_hi + 1; end
            hi = 0; lo = lo + 1;
            ilim = 1'b0;
            if (plant_val && lo >= val_at) valley = 1'b1;
        end
    end

    function automatic int f_on(int a);
        return (a + 2 < TON) ? a + 2 : TON;
    endfunction
    function automatic int f_off_fast(int v);
        return (v + 2 < TOFF_M) ? v + 2 : TOFF_M;
    endfunction

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_hi(int k);
        int b = n_hi;
        while (n_hi < b + k) @(posedge clk);
    endtask
    task automatic wait_lo(int k);
        int b = n_lo;
        while (n_lo < b + k) @(posedge clk);
    endtask
    task automatic cyc(int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask
    // count gate-high samples over a window
    task automatic win_highs(int k, output int cnt, output int done_lows);
        cnt = 0; done_lows = 0;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            if (gate) cnt++;
            if (!done_n) done_lows++;
        end
    endtask

    // Watchdog
    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int h, d, b;
        void'($urandom(32'd4711));
        cyc(5);
        // R1: reset state
        chk("R1 gate", gate, 0);
        chk("R1 done_n", done_n, 1);
        @(negedge clk); rst_n = 1'b1;
        cyc(3);
        chk("R1 gate after reset", gate, 0);

        // R3/R4: no limit flag, no valley
        chg_en = 1'b1;
        wait_hi(2);
        chk("R3 max on-time", last_hi, TON);
        wait_lo(1);
        chk("R4 soft off-time", last_lo, TOFF_F);

        // R3: random current-limit points
        plant_ilim = 1;
        for (int i = 0; i < 6; i++) begin
            ilim_at = $urandom_range(45, 1);
            wait_hi(2);
            chk("R3 ilim on-time", last_hi, f_on(ilim_at));
            wait_lo(1);
            chk("R4 soft off-time", last_lo, TOFF_F);
        end

        // R5: valley qualifies, move to fast mode
        ilim_at = 8;
        val_at = 5; plant_val = 1;
        wait_lo(FAST + 2);
        chk("R5 fast off-time", last_lo, f_off_fast(val_at));
        for (int i = 0; i < 6; i++) begin
            val_at = $urandom_range(40, 1);
            wait_lo(2);
            chk("R5 R6 fast off-time", last_lo, f_off_fast(val_at));
        end
        // R6: no valley in fast mode
        plant_val = 0;
        wait_lo(2);
        chk("R6 off timeout", last_lo, TOFF_M);
        plant_val = 1; val_at = 3;

        // R7: target trip
        @(negedge clk); target = 1'b1;
        cyc(2);
        chk("R7 done not yet", done_n, 1);
        cyc(1);
        chk("R7 done low", done_n, 0);
        chk("R7 gate off", gate, 0);
        win_highs(60, h, d);
        chk("R7 no switching", h, 0);
        target = 1'b0;
        cyc(10);
        chk("R7 done held", done_n, 0);

        // R8: regulated recharge
        @(negedge clk); reg_low = 1'b1;
        cyc(3);
        chk("R8 done released", done_n, 1);
        reg_low = 1'b0;
        wait_lo(2);
        chk("R8 R5 fast kept in recharge", last_lo, f_off_fast(val_at));
        @(negedge clk); target = 1'b1;
        cyc(3);
        chk("R8 done again", done_n, 0);
        target = 1'b0;

        // R11: halt during recharge
        @(negedge clk); reg_low = 1'b1;
        cyc(4); reg_low = 1'b0;
        wait_hi(1);
        @(negedge clk); halt = 1'b1;
        cyc(3);
        chk("R11 gate off on halt", gate, 0);
        win_highs(50, h, d);
        chk("R11 no pulses while halted", h, 0);
        chk("R11 done high while halted", d, 0);
        b = n_hi;
        halt = 1'b0;
        cyc(200);
        chk("R11 resumes after halt", (n_hi > b) ? 1 : 0, 1);

        // R9: regulation strapped off
        @(negedge clk); target = 1'b1;
        cyc(5);
        chk("R7 done low before strap test", done_n, 0);
        reg_off = 1'b1; target = 1'b0; reg_low = 1'b1;
        win_highs(50, h, d);
        chk("R9 no recharge", h, 0);
        chk("R9 done held low", d, 50);
        reg_low = 1'b0;

        // R2: short enable glitch ignored
        @(negedge clk); chg_en = 1'b0;
        cyc(FILT / 2);
        chg_en = 1'b1;
        cyc(40);
        chk("R2 glitch ignored", done_n, 0);

        // R2/R10: exact enable-low latency
        @(negedge clk); chg_en = 1'b0;
        for (int i = 1; i <= FILT + 3; i++) begin
            @(negedge clk);
            if (i == FILT + 2) chk("R2 done before filter", done_n, 0);
            if (i == FILT + 3) chk("R2 R10 done after filter", done_n, 1);
        end
        chk("R10 gate off", gate, 0);
        reg_off = 1'b0;
        cyc(10);

        // R10/R11/R5: restart from standby with halt held (ignored), soft again
        halt = 1'b1; val_at = 3; plant_val = 1;
        @(posedge clk); clr_tok++;
        @(negedge clk); b = n_hi; chg_en = 1'b1;
        wait_lo(1);
        chk("R11 halt ignored on first charge", (n_hi > b) ? 1 : 0, 1);
        chk("R10 soft after standby", last_lo, TOFF_F);
        wait_lo(FAST - 1);
        chk("R5 still soft at streak end", last_lo, TOFF_F);
        wait_lo(1);
        chk("R5 fast after streak", last_lo, f_off_fast(val_at));
        halt = 1'b0;

        // R12: undervoltage
        @(negedge clk); uvlo = 1'b1;
        cyc(3);
        chk("R12 gate off", gate, 0);
        win_highs(50, h, d);
        chk("R12 no pulses", h, 0);
        chk("R12 done high", d, 0);
        b = n_hi;
        uvlo = 1'b0;
        cyc(200);
        chk("R12 resumes", (n_hi > b) ? 1 : 0, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule